// File: doc/BRIEF.md
# Power Control Register Block

This block is the software-visible face of a chip's power manager. It keeps the configuration bits that steer the power state machinery: regulator behaviour in stop, the choice between stop and standby on deep sleep, the supply-detector enable and its threshold, backup-domain write enable, flash power-down in stop, the regulator scale, the wakeup-pin enable and the backup-regulator enable. It also keeps two sticky status flags. The wake flag records wakeup events. The standby flag records a resume from standby. Live status from the analog side is shown next to these flags. The analog detector, the regulators and the real-time clock are outside the block. They appear only as plain input signals.

Software reaches the block over a plain 32-bit register bus with two registers. Offset 0 is the control register. Offset 4 is the control/status register. The bus has no handshake and never back-pressures. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is combinational on `bus_addr` and is valid in the same cycle. The wakeup pin and the three analog status inputs are asynchronous. Each passes through `SYNC_STAGES` flip-flops before it is used. The real-time-clock event inputs and the standby-resume input are single-cycle pulses that are already synchronous to `clk`.

Top module: `pwr_ctl`

## Requirements
- R1: After system reset (`rst_n` low), every control field, the wake flag and the standby flag read 0, and every control output is 0.
- R2: Control register (offset 0) bit layout:
  - bit 0: regulator low-power in stop
  - bit 1: standby on deep sleep
  - bit 4: detector enable
  - bits 7:5: detector threshold
  - bit 8: backup-domain write enable
  - bit 9: flash power-down in stop
  - bit 14: regulator scale 1
  
  These bits read back as written and drive their output pins from the edge after the write. All other bits of this register read 0.
- R3: Control/status register (offset 4): bit 8 (wakeup-pin enable) and bit 9 (backup-regulator enable) are writable. Bits 0, 1, 2, 3 and 14 are status bits, and writes to them are ignored. All remaining bits read 0.
- R4: Writing 1 to control bit 2 clears the wake flag (status bit 0), and writing 1 to control bit 3 clears the standby flag (status bit 1), each from the next edge. Control bits 2 and 3 always read 0.
- R5: While the wakeup-pin enable is 1, a rising edge of the synchronised wakeup pin sets the wake flag. While the enable is 0, the pin has no effect.
- R6: When the wakeup-pin enable goes from 0 to 1 while the synchronised pin is already high, the wake flag is set.
- R7: A pulse on any bit of `rtc_evt` sets the wake flag, whatever the state of the wakeup-pin enable.
- R8: A pulse on `stby_resume` sets the standby flag. Without a set or clear, the flag holds its value.
- R9: When a set event and a clear command hit the same flag in the same cycle, the flag ends up 1.
- R10: Status bit 2 equals the synchronised detector input while the detector enable is 1, and reads 0 in any cycle where the enable is 0.
- R11: Status bit 3 follows the synchronised backup-regulator-ready input. It is unaffected by system reset and is cleared only by `bkp_rst_n`.
- R12: Status bit 14 follows the synchronised scale-ready input.
- R13: Addresses other than 0 and 4 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| bkp_rst_n | input | 1 | Backup-domain reset, active low, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| wkup_pin | input | 1 | Wakeup pin level, asynchronous |
| rtc_evt | input | N_RTC_EVT | Real-time-clock alarm/wakeup/tamper/time-stamp pulses |
| stby_resume | input | 1 | Pulse: system resumed from standby |
| det_in | input | 1 | Supply-detector comparator output, asynchronous |
| bkreg_rdy_in | input | 1 | Backup regulator ready, asynchronous |
| scale_rdy_in | input | 1 | Regulator scale ready, asynchronous |
| lp_reg_stop | output | 1 | Regulator low-power in stop |
| stby_on_deep | output | 1 | Deep sleep enters standby instead of stop |
| det_en | output | 1 | Supply-detector enable |
| det_level | output | 3 | Detector threshold select |
| bkp_wr_en | output | 1 | Backup-domain write enable |
| flash_pd_stop | output | 1 | Flash power-down in stop |
| reg_scale1 | output | 1 | Regulator scale 1 select |
| wkup_pin_en | output | 1 | Wakeup-pin enable |
| bkreg_en | output | 1 | Backup-regulator enable |

## Verification
Every piece of internal state is readable at a register offset, so a wrong value shows on `bus_rdata` in the first cycle after the edge that produced it. Configuration state also shows on the control output pins in that cycle. A wrong edge-detector memory or a missed set-over-clear priority appears as a wake flag that is set or clear one edge later than expected. A bad synchroniser length shifts the status bits by a whole cycle. The reference model is compared on every falling edge, so both kinds of fault are caught in the cycle where they first become visible.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int REG_W = 32;
  localparam int CR_OFF = 0;
  localparam int CSR_OFF = 4;

  // status register positions
  localparam int ST_WUF = 0;
  localparam int ST_SBF = 1;
  localparam int ST_DET = 2;
  localparam int ST_BKRDY = 3;
  localparam int ST_PIN_EN = 8;
  localparam int ST_BKREG_EN = 9;
  localparam int ST_SCRDY = 14;

  // control register positions; clear commands sit two above their flag
  localparam int CT_LPREG = 0;
  localparam int CT_STBY = 1;
  localparam int CT_CLR_WU = ST_WUF + 2;
  localparam int CT_CLR_SB = ST_SBF + 2;
  localparam int CT_DET_EN = 4;
  localparam int CT_LVL_LO = 5;
  localparam int CT_LVL_W = 3;
  localparam int CT_BKP_WE = 8;
  localparam int CT_FLASH_PD = 9;
  localparam int CT_SCALE1 = 14;

  typedef struct packed {
    logic                lp_reg;
    logic                stby_sel;
    logic                det_en;
    logic [CT_LVL_W-1:0] det_lvl;
    logic                bkp_we;
    logic                flash_pd;
    logic                scale1;
    logic                pin_en;
    logic                bkreg_en;
  } pwr_ctl_t;

  typedef struct packed {
    logic wuf;
    logic sbf;
    logic det;
    logic bkrdy;
    logic scrdy;
  } pwr_sts_t;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_flags.sv
module pwr_flags #(
  parameter int N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_lvl,
  input  logic             pin_en,
  input  logic [N_EVT-1:0] rtc_evt,
  input  logic             stby_evt,
  input  logic             clr_wu,
  input  logic             clr_sb,
  output logic             wake_set,
  output logic             wuf,
  output logic             sbf
);
  // one memory covers both a pin edge and an enable edge while the pin is high
  logic armed, armed_q;

  assign armed    = pin_en & pin_lvl;
  assign wake_set = (armed & ~armed_q) | (|rtc_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      wuf     <= 1'b0;
      sbf     <= 1'b0;
    end else begin
      armed_q <= armed;
      if (wake_set)    wuf <= 1'b1;
      else if (clr_wu) wuf <= 1'b0;
      if (stby_evt)    sbf <= 1'b1;
      else if (clr_sb) sbf <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_regfile.sv
module pwr_regfile
  import pwr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  pwr_sts_t          sts,
  output pwr_ctl_t          ctl,
  output logic              clr_wu,
  output logic              clr_sb,
  output logic [REG_W-1:0]  bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CR  = ADDR_W'(CR_OFF);
  localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(CSR_OFF);

  logic wr_cr, wr_csr;
  logic [REG_W-1:0] cr_img, csr_img;
  logic unused_wdata;

  assign wr_cr  = bus_sel & bus_wr & (bus_addr == A_CR);
  assign wr_csr = bus_sel & bus_wr & (bus_addr == A_CSR);
  assign clr_wu = wr_cr & bus_wdata[CT_CLR_WU];
  assign clr_sb = wr_cr & bus_wdata[CT_CLR_SB];
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (wr_cr) begin
        ctl.lp_reg   <= bus_wdata[CT_LPREG];
        ctl.stby_sel <= bus_wdata[CT_STBY];
        ctl.det_en   <= bus_wdata[CT_DET_EN];
        ctl.det_lvl  <= bus_wdata[CT_LVL_LO +: CT_LVL_W];
        ctl.bkp_we   <= bus_wdata[CT_BKP_WE];
        ctl.flash_pd <= bus_wdata[CT_FLASH_PD];
        ctl.scale1   <= bus_wdata[CT_SCALE1];
      end
      if (wr_csr) begin
        ctl.pin_en   <= bus_wdata[ST_PIN_EN];
        ctl.bkreg_en <= bus_wdata[ST_BKREG_EN];
      end
    end
  end

  always_comb begin
    cr_img = '0;
    cr_img[CT_LPREG]                 = ctl.lp_reg;
    cr_img[CT_STBY]                  = ctl.stby_sel;
    cr_img[CT_DET_EN]                = ctl.det_en;
    cr_img[CT_LVL_LO +: CT_LVL_W]    = ctl.det_lvl;
    cr_img[CT_BKP_WE]                = ctl.bkp_we;
    cr_img[CT_FLASH_PD]              = ctl.flash_pd;
    cr_img[CT_SCALE1]                = ctl.scale1;

    csr_img = '0;
    csr_img[ST_WUF]      = sts.wuf;
    csr_img[ST_SBF]      = sts.sbf;
    csr_img[ST_DET]      = sts.det;
    csr_img[ST_BKRDY]    = sts.bkrdy;
    csr_img[ST_PIN_EN]   = ctl.pin_en;
    csr_img[ST_BKREG_EN] = ctl.bkreg_en;
    csr_img[ST_SCRDY]    = sts.scrdy;

    if (bus_addr == A_CR)       bus_rdata = cr_img;
    else if (bus_addr == A_CSR) bus_rdata = csr_img;
    else                        bus_rdata = '0;
  end
endmodule

// File: rtl/pwr_ctl.sv
module pwr_ctl
  import pwr_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int N_RTC_EVT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bkp_rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 wkup_pin,
  input  logic [N_RTC_EVT-1:0] rtc_evt,
  input  logic                 stby_resume,
  input  logic                 det_in,
  input  logic                 bkreg_rdy_in,
  input  logic                 scale_rdy_in,
  output logic                 lp_reg_stop,
  output logic                 stby_on_deep,
  output logic                 det_en,
  output logic [2:0]           det_level,
  output logic                 bkp_wr_en,
  output logic                 flash_pd_stop,
  output logic                 reg_scale1,
  output logic                 wkup_pin_en,
  output logic                 bkreg_en
);
  localparam int N_SYS_IN = 3;

  pwr_ctl_t ctl;
  pwr_sts_t sts;
  logic clr_wu, clr_sb, wake_set, wuf, sbf;
  logic pin_s, det_s, scr_s, bkr_s;

  // system-domain inputs share one synchroniser bank
  pwr_sync #(.WIDTH(N_SYS_IN), .STAGES(SYNC_STAGES)) u_sync_sys (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({wkup_pin, det_in, scale_rdy_in}),
    .q     ({pin_s, det_s, scr_s})
  );

  // backup-domain ready survives system reset
  pwr_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync_bkp (
    .clk   (clk),
    .rst_n (bkp_rst_n),
    .d     (bkreg_rdy_in),
    .q     (bkr_s)
  );

  pwr_flags #(.N_EVT(N_RTC_EVT)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_s),
    .pin_en   (ctl.pin_en),
    .rtc_evt  (rtc_evt),
    .stby_evt (stby_resume),
    .clr_wu   (clr_wu),
    .clr_sb   (clr_sb),
    .wake_set (wake_set),
    .wuf      (wuf),
    .sbf      (sbf)
  );

  assign sts.wuf   = wuf;
  assign sts.sbf   = sbf;
  assign sts.det   = ctl.det_en & det_s;
  assign sts.bkrdy = bkr_s;
  assign sts.scrdy = scr_s;

  pwr_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sts       (sts),
    .ctl       (ctl),
    .clr_wu    (clr_wu),
    .clr_sb    (clr_sb),
    .bus_rdata (bus_rdata)
  );

  assign lp_reg_stop   = ctl.lp_reg;
  assign stby_on_deep  = ctl.stby_sel;
  assign det_en        = ctl.det_en;
  assign det_level     = ctl.det_lvl;
  assign bkp_wr_en     = ctl.bkp_we;
  assign flash_pd_stop = ctl.flash_pd;
  assign reg_scale1    = ctl.scale1;
  assign wkup_pin_en   = ctl.pin_en;
  assign bkreg_en      = ctl.bkreg_en;
endmodule

// File: rtl/pwr_ctl_chk.sv
module pwr_ctl_chk #(
  parameter int ADDR_W    = 4,
  parameter int N_RTC_EVT = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [1:0]           clr_req,
  input logic [1:0]           rd_lo,
  input logic                 rd_det,
  input logic [N_RTC_EVT-1:0] rtc_evt,
  input logic                 stby_resume,
  input logic                 det_en,
  input logic                 wkup_pin_en,
  input logic                 wake_set,
  input logic                 wuf,
  input logic                 sbf
);
  localparam logic [ADDR_W-1:0] A_CR  = ADDR_W'(pwr_pkg::CR_OFF);
  localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(pwr_pkg::CSR_OFF);

  logic cr_wr;
  assign cr_wr = bus_sel && bus_wr && (bus_addr == A_CR);

  p_clear_wu_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr && clr_req[0] && !wake_set) |=> !wuf);

  p_clr_bits_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CR) |-> (rd_lo == 2'b00));

  p_pin_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wkup_pin_en && rtc_evt == '0) |=> !$rose(wuf));

  p_sb_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stby_resume |=> sbf);

  p_sb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_resume && !(cr_wr && clr_req[1])) |=> $stable(sbf));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_set |=> wuf);

  p_det_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CSR && !det_en) |-> !rd_det);
endmodule

bind pwr_ctl pwr_ctl_chk #(.ADDR_W(ADDR_W), .N_RTC_EVT(N_RTC_EVT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .clr_req     (bus_wdata[3:2]),
  .rd_lo       (bus_rdata[3:2]),
  .rd_det      (bus_rdata[2]),
  .rtc_evt     (rtc_evt),
  .stby_resume (stby_resume),
  .det_en      (det_en),
  .wkup_pin_en (wkup_pin_en),
  .wake_set    (wake_set),
  .wuf         (wuf),
  .sbf         (sbf)
);

// File: tb/pwr_ctl_tb.sv
module pwr_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 4;
  localparam int NEVT = 4;
  localparam int SYNC = 2;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst_n, bkp_rst_n, bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic wkup_pin, stby_resume, det_in, bkreg_rdy_in, scale_rdy_in;
  logic [NEVT-1:0] rtc_evt;
  logic lp_reg_stop, stby_on_deep, det_en, bkp_wr_en, flash_pd_stop;
  logic reg_scale1, wkup_pin_en, bkreg_en;
  logic [2:0] det_level;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  pwr_ctl #(.ADDR_W(AW), .N_RTC_EVT(NEVT), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bkp_rst_n(bkp_rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wkup_pin(wkup_pin), .rtc_evt(rtc_evt), .stby_resume(stby_resume),
    .det_in(det_in), .bkreg_rdy_in(bkreg_rdy_in), .scale_rdy_in(scale_rdy_in),
    .lp_reg_stop(lp_reg_stop), .stby_on_deep(stby_on_deep), .det_en(det_en),
    .det_level(det_level), .bkp_wr_en(bkp_wr_en), .flash_pd_stop(flash_pd_stop),
    .reg_scale1(reg_scale1), .wkup_pin_en(wkup_pin_en), .bkreg_en(bkreg_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cr = 0;
  logic m_wken = 0, m_bken = 0, m_wuf = 0, m_sbf = 0, m_armed = 0;
  logic [SYNC-1:0] pin_p = 0, det_p = 0, scr_p = 0, bkr_p = 0;

  always @(posedge clk) begin
    logic armed_now, ws, wcr, wcsr;
    if (!rst_n) begin
      m_cr = 0; m_wken = 0; m_bken = 0; m_wuf = 0; m_sbf = 0; m_armed = 0;
      pin_p = 0; det_p = 0; scr_p = 0;
    end else begin
      armed_now = m_wken & pin_p[SYNC-1];
      ws = (armed_now & !m_armed) | (rtc_evt != 0);
      m_armed = armed_now;
      wcr  = bus_sel && bus_wr && bus_addr == 0;
      wcsr = bus_sel && bus_wr && bus_addr == 4;
      if (ws) m_wuf = 1; else if (wcr && bus_wdata[2]) m_wuf = 0;
      if (stby_resume) m_sbf = 1; else if (wcr && bus_wdata[3]) m_sbf = 0;
      if (wcr) m_cr = bus_wdata & 32'h0000_43F3;
      if (wcsr) begin m_wken = bus_wdata[8]; m_bken = bus_wdata[9]; end
      pin_p = {pin_p[SYNC-2:0], wkup_pin};
      det_p = {det_p[SYNC-2:0], det_in};
      scr_p = {scr_p[SYNC-2:0], scale_rdy_in};
    end
    if (!bkp_rst_n) bkr_p = 0;
    else bkr_p = {bkr_p[SYNC-2:0], bkreg_rdy_in};
  end

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    logic [31:0] v;
    v = 0;
    if (a == 0) v = m_cr;
    else if (a == 4) begin
      v[0] = m_wuf; v[1] = m_sbf; v[2] = m_cr[4] & det_p[SYNC-1];
      v[3] = bkr_p[SYNC-1]; v[8] = m_wken; v[9] = m_bken; v[14] = scr_p[SYNC-1];
    end
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // compared on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      check((bus_addr == 0) ? "R2 cycle read" : (bus_addr == 4) ? "R3 cycle read" : "R13 cycle read",
            bus_rdata, model_read(bus_addr));
      check("R2 cycle pins",
            {23'd0, lp_reg_stop, stby_on_deep, det_en, det_level, bkp_wr_en, flash_pd_stop, reg_scale1},
            {23'd0, m_cr[0], m_cr[1], m_cr[4], m_cr[7:5], m_cr[8], m_cr[9], m_cr[14]});
      check("R3 cycle pins", {30'd0, wkup_pin_en, bkreg_en}, {30'd0, m_wken, m_bken});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(string req, logic [AW-1:0] a, logic [31:0] mask, logic [31:0] exp);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    check(req, bus_rdata & mask, exp & mask);
    bus_sel = 0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=finished", WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bkp_rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    wkup_pin = 0; rtc_evt = 0; stby_resume = 0; det_in = 0; bkreg_rdy_in = 0; scale_rdy_in = 0;
    step(3);
    rst_n = 1; bkp_rst_n = 1;
    step(1);

    // R1 reset state
    rd("R1 control after reset", 0, 32'hFFFF_FFFF, 0);
    rd("R1 status after reset", 4, 32'hFFFF_FFFF, 0);
    check("R1 pins after reset", {29'd0, det_level}, 0);

    // R2 field layout and readback
    wr(0, 32'hFFFF_FFFF);
    rd("R2 all-ones readback", 0, 32'hFFFF_FFFF, 32'h0000_43F3);
    check("R2 threshold pins", {29'd0, det_level}, 7);
    wr(0, 32'h0000_0121);
    rd("R2 pattern readback", 0, 32'hFFFF_FFFF, 32'h0000_0121);
    check("R2 pattern pins", {26'd0, lp_reg_stop, det_level, bkp_wr_en, reg_scale1}, {26'd0, 1'b1, 3'd1, 1'b1, 1'b0});

    // R3 status bits are read-only
    wr(4, 32'hFFFF_FFFF);
    rd("R3 status ignores writes", 4, 32'hFFFF_FFFF, 32'h0000_0300);

    // R5 pin edge while enabled
    wkup_pin = 1; step(4);
    rd("R5 edge sets wake flag", 4, 32'h1, 32'h1);
    // R4 clear command
    wr(0, 32'h0000_0125);
    rd("R4 wake flag cleared", 4, 32'h1, 0);
    rd("R4 clear bits read 0", 0, 32'hC, 0);
    step(3);
    rd("R5 steady high no retrigger", 4, 32'h1, 0);
    // R5 disabled pin ignored
    wr(4, 32'h0000_0200);
    wkup_pin = 0; step(4); wkup_pin = 1; step(4);
    rd("R5 disabled pin ignored", 4, 32'h1, 0);
    // R6 enable while high
    wr(4, 32'h0000_0300); step(2);
    rd("R6 enable while high", 4, 32'h1, 32'h1);
    wr(4, 32'h0000_0200); wr(0, 32'h0000_0125);
    rd("R4 wake flag cleared again", 4, 32'h1, 0);

    // R7 each event input
    for (int k = 0; k < NEVT; k++) begin
      rtc_evt[k] = 1; step(1); rtc_evt = 0; step(1);
      rd("R7 event sets wake flag", 4, 32'h1, 32'h1);
      wr(0, 32'h0000_0125);
      rd("R7 wake flag cleared", 4, 32'h1, 0);
    end

    // R9 set beats clear
    rtc_evt[1] = 1; bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 32'h0000_0125;
    step(1);
    rtc_evt = 0; bus_sel = 0; bus_wr = 0;
    rd("R9 wake set beats clear", 4, 32'h1, 32'h1);
    stby_resume = 1; bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 32'h0000_0129;
    step(1);
    stby_resume = 0; bus_sel = 0; bus_wr = 0;
    rd("R9 standby set beats clear", 4, 32'h2, 32'h2);
    wr(0, 32'h0000_012D);
    rd("R4 both flags cleared", 4, 32'h3, 0);

    // R8 standby flag
    stby_resume = 1; step(1); stby_resume = 0; step(3);
    rd("R8 standby flag set and held", 4, 32'h3, 32'h2);
    wr(0, 32'h0000_0129);
    rd("R4 standby flag cleared", 4, 32'h2, 0);

    // R10 detector gating
    det_in = 1; step(3);
    rd("R10 detector gated off", 4, 32'h4, 0);
    wr(0, 32'h0000_0131);
    rd("R10 detector visible", 4, 32'h4, 32'h4);
    wr(0, 32'h0000_0121);
    rd("R10 detector reads 0 when disabled", 4, 32'h4, 0);

    // R12 scale ready
    scale_rdy_in = 1; step(3);
    rd("R12 scale ready", 4, 32'h4000, 32'h4000);

    // R13 unmapped addresses
    rd("R13 unmapped read", 8, 32'hFFFF_FFFF, 0);
    wr(8, 32'hFFFF_FFFF); wr(12, 32'hFFFF_FFFF);
    rd("R13 control untouched", 0, 32'hFFFF_FFFF, 32'h0000_0121);
    rd("R13 status untouched", 4, 32'hFFFF_FFFF, 32'h0000_4200);

    // R11 backup ready survives system reset
    bkreg_rdy_in = 1; step(3);
    rd("R11 ready visible", 4, 32'h8, 32'h8);
    rst_n = 0; step(2); rst_n = 1; step(1);
    rd("R11 ready kept over system reset", 4, 32'h8, 32'h8);
    rd("R1 control cleared by system reset", 0, 32'hFFFF_FFFF, 0);
    bkp_rst_n = 0; step(1);
    rd("R11 backup reset clears ready", 4, 32'h8, 0);
    bkp_rst_n = 1; step(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule